// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a windowed register file for a processor that gives every procedure activation its own set of registers. Software addresses 32 logical registers through a 5-bit number; a current-window pointer turns that number into a physical entry of a circular file of `NWIN` windows. Logical registers 0 to 7 are globals, held apart from the windows and seen the same from every procedure. Registers 8 to 15 are the window's parameters, 16 to 23 its locals, and 24 to 31 its temporaries. The temporaries of one window are the same physical entries as the parameters of the next window, so a caller passes arguments to its callee with no copy.

A call pulse moves the pointer forward by one window and a return pulse moves it back by one. The file holds at most `NWIN-1` live activations. A call made with the file full raises an overflow trap and names the window to be saved. A return made with only one activation resident raises an underflow trap and names the window to be restored. While a trap is pending, trap logic reaches that window's sixteen parameter and local entries through a spill and fill port. An acknowledge pulse then completes the deferred call or return. The block has two combinational read ports and one write port.

Top module: `rwin_file`

## Requirements
- R1: After reset the window pointer is 0, one activation is resident and neither trap output is high.
- R2: A windowed register r (8 to 31) in window w reaches physical entry (16*w + r - 8) modulo 16*NWIN. A write is seen on the read ports from the next cycle on.
- R3: After a call, registers 8 to 15 of the callee are the same storage as registers 24 to 31 of the caller. A write to either one is seen through the other.
- R4: Registers 1 to 7 are a single global set that reads back the same value from every window.
- R5: Register 0 always reads as zero, and a write to it has no effect.
- R6: With fewer than NWIN-1 activations resident, a call sets the pointer to (w+1) mod NWIN. With more than one resident, a return sets it to (w-1) mod NWIN.
- R7: A call made while NWIN-1 activations are resident raises the overflow trap and reports window (w+2) mod NWIN. The pointer holds until the acknowledge pulse, and then moves to (w+1) mod NWIN.
- R8: A return made while one activation is resident raises the underflow trap and reports window (w-1) mod NWIN. The pointer holds until the acknowledge pulse, and then moves to (w-1) mod NWIN.
- R9: While a trap is pending, spill index 0 to 7 selects parameter registers 8 to 15 of the reported window and index 8 to 15 selects its locals 16 to 23. The spill port reads these combinationally, and a spill write updates the entry from the next cycle on.
- R10: Reads and writes issued in the same cycle as a call or return use the window that was current before the change.
- R11: A call and a return asserted together have no effect. A call or return that arrives while a trap is pending is ignored.
- R12: A read of a register written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Procedure call pulse |
| ret_i | input | 1 | Procedure return pulse |
| rd_a_idx_i | input | 5 | Logical register number, read port A |
| rd_a_o | output | DW | Read data, port A |
| rd_b_idx_i | input | 5 | Logical register number, read port B |
| rd_b_o | output | DW | Read data, port B |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Logical register number for the write |
| wr_data_i | input | DW | Write data |
| cwp_o | output | CW | Current window pointer |
| ovf_trap_o | output | 1 | Overflow trap pending |
| unf_trap_o | output | 1 | Underflow trap pending |
| trap_win_o | output | CW | Window to save or restore |
| trap_ack_i | input | 1 | Spill or fill finished |
| sf_idx_i | input | 4 | Entry of the trap window (0-7 parameters, 8-15 locals) |
| sf_we_i | input | 1 | Fill write enable, honoured only while a trap is pending |
| sf_wdata_i | input | DW | Fill data |
| sf_rdata_o | output | DW | Spill read data |

## Verification
Directed sequences first fill the globals and every register of window 0. They then step through calls and returns. One write made in the callee's parameters is read back through the caller's temporaries, which shows the overlap and rules out an off-by-one in the window base. The file is filled until it overflows and then drained until it underflows. A spill read, a fill write and the acknowledge in each case show which window is reported and when the pointer moves. After that, a long random mix of writes, reads, calls, returns, trap acknowledges and spill writes is compared every cycle against a behavioural model. The mix includes calls and returns while a trap is pending and calls together with returns. This mix catches pointer wrap errors and wrong priority between a spill write and a normal write.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int LREG_W   = 5;
  localparam int WIN_SPAN = 16;
  localparam int NGLOB    = 8;

  typedef enum logic [1:0] {
    WS_RUN = 2'd0,
    WS_OVF = 2'd1,
    WS_UNF = 2'd2
  } win_state_e;
endpackage

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int CW  = (NWIN > 2) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          ack_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic [CW-1:0] trap_win_o
);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  win_state_e    st_q, st_d;
  logic [CW-1:0] cwp_q, cwp_d, occ_q, occ_d;
  logic [CW-1:0] cwp_inc, cwp_inc2, cwp_dec;
  logic          upd_en;

  assign cwp_inc  = (cwp_q == LAST) ? '0 : cwp_q + 1'b1;
  assign cwp_inc2 = (cwp_inc == LAST) ? '0 : cwp_inc + 1'b1;
  assign cwp_dec  = (cwp_q == '0) ? LAST : cwp_q - 1'b1;
  assign upd_en   = call_i | ret_i | ack_i;

  always_comb begin
    st_d  = st_q;
    cwp_d = cwp_q;
    occ_d = occ_q;
    case (st_q)
      WS_RUN: begin
        if (call_i && !ret_i) begin
          if (occ_q == LAST) st_d = WS_OVF;
          else begin
            cwp_d = cwp_inc;
            occ_d = occ_q + 1'b1;
          end
        end else if (ret_i && !call_i) begin
          if (occ_q == CW'(1)) st_d = WS_UNF;
          else begin
            cwp_d = cwp_dec;
            occ_d = occ_q - 1'b1;
          end
        end
      end
      WS_OVF: if (ack_i) begin
        cwp_d = cwp_inc;
        st_d  = WS_RUN;
      end
      WS_UNF: if (ack_i) begin
        cwp_d = cwp_dec;
        st_d  = WS_RUN;
      end
      default: st_d = WS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_RUN;
      cwp_q <= '0;
      occ_q <= CW'(1);
    end else if (upd_en) begin
      st_q  <= st_d;
      cwp_q <= cwp_d;
      occ_q <= occ_d;
    end
  end

  assign cwp_o      = cwp_q;
  assign ovf_o      = (st_q == WS_OVF);
  assign unf_o      = (st_q == WS_UNF);
  assign trap_win_o = (st_q == WS_OVF) ? cwp_inc2 : cwp_dec;

  AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q >= CW'(1)) && (occ_q <= LAST)); // R6
  AST_CALL_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_RUN && call_i && !ret_i && occ_q != LAST)
    |=> (int'(cwp_q) == (int'($past(cwp_q)) + 1) % NWIN)); // R6
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> ($past(occ_q) == LAST)); // R7
  AST_UNF_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_o) |-> ($past(occ_q) == CW'(1))); // R8
  AST_TRAP_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_o || unf_o) && !ack_i) |=> ($stable(cwp_q) && (ovf_o || unf_o))); // R11
endmodule

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int CW    = (NWIN > 2) ? $clog2(NWIN) : 1,
  localparam int NPHYS = NWIN * WIN_SPAN,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic [CW-1:0]     cwp_i,
  input  logic [LREG_W-1:0] lreg_i,
  output logic              glob_o,
  output logic [2:0]        gidx_o,
  output logic [PW-1:0]     pidx_o
);
  logic [PW:0] raw;

  assign raw    = (PW+1)'(cwp_i) * (PW+1)'(WIN_SPAN) + (PW+1)'(lreg_i) - (PW+1)'(NGLOB);
  assign pidx_o = (raw >= (PW+1)'(NPHYS)) ? PW'(raw - (PW+1)'(NPHYS)) : PW'(raw);
  assign glob_o = (lreg_i[LREG_W-1:3] == '0);
  assign gidx_o = lreg_i[2:0];
endmodule

// File: rtl/rwin_store.sv
module rwin_store
  import rwin_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPHYS = 64,
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_glob_i,
  input  logic [2:0]    a_gidx_i,
  input  logic [PW-1:0] a_pidx_i,
  output logic [DW-1:0] a_data_o,
  input  logic          b_glob_i,
  input  logic [2:0]    b_gidx_i,
  input  logic [PW-1:0] b_pidx_i,
  output logic [DW-1:0] b_data_o,
  input  logic          w_en_i,
  input  logic          w_glob_i,
  input  logic [2:0]    w_gidx_i,
  input  logic [PW-1:0] w_pidx_i,
  input  logic [DW-1:0] w_data_i,
  input  logic          sf_we_i,
  input  logic [PW-1:0] sf_pidx_i,
  input  logic [DW-1:0] sf_wdata_i,
  output logic [DW-1:0] sf_rdata_o
);
  logic [DW-1:0] win_mem  [NPHYS];
  logic [DW-1:0] glob_mem [1:NGLOB-1];
  logic          wen_win, wen_glob;

  assign wen_win  = w_en_i && !w_glob_i;
  assign wen_glob = w_en_i && w_glob_i && (w_gidx_i != 3'd0);

  always_ff @(posedge clk) begin
    if (wen_win)  win_mem[w_pidx_i]   <= w_data_i;
    if (sf_we_i)  win_mem[sf_pidx_i]  <= sf_wdata_i;
    if (wen_glob) glob_mem[w_gidx_i]  <= w_data_i;
  end

  assign a_data_o   = a_glob_i ? ((a_gidx_i == 3'd0) ? '0 : glob_mem[a_gidx_i]) : win_mem[a_pidx_i];
  assign b_data_o   = b_glob_i ? ((b_gidx_i == 3'd0) ? '0 : glob_mem[b_gidx_i]) : win_mem[b_pidx_i];
  assign sf_rdata_o = win_mem[sf_pidx_i];

  AST_WIN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_win && !(sf_we_i && sf_pidx_i == w_pidx_i))
    |=> (win_mem[$past(w_pidx_i)] == $past(w_data_i))); // R2
endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int DW   = 32,
  localparam int CW    = (NWIN > 2) ? $clog2(NWIN) : 1,
  localparam int NPHYS = NWIN * WIN_SPAN,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [4:0]    rd_a_idx_i,
  output logic [DW-1:0] rd_a_o,
  input  logic [4:0]    rd_b_idx_i,
  output logic [DW-1:0] rd_b_o,
  input  logic          wr_en_i,
  input  logic [4:0]    wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_trap_o,
  output logic          unf_trap_o,
  output logic [CW-1:0] trap_win_o,
  input  logic          trap_ack_i,
  input  logic [3:0]    sf_idx_i,
  input  logic          sf_we_i,
  input  logic [DW-1:0] sf_wdata_i,
  output logic [DW-1:0] sf_rdata_o
);
  logic [CW-1:0] cwp, twin;
  logic          ovf, unf, pend;
  logic [PW-1:0] sf_pidx;

  localparam int NPORT = 3;
  logic [LREG_W-1:0] port_lreg [NPORT];
  logic              port_glob [NPORT];
  logic [2:0]        port_gidx [NPORT];
  logic [PW-1:0]     port_pidx [NPORT];

  assign port_lreg[0] = rd_a_idx_i;
  assign port_lreg[1] = rd_b_idx_i;
  assign port_lreg[2] = wr_idx_i;

  rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .ack_i(trap_ack_i),
    .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf), .trap_win_o(twin)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rwin_map #(.NWIN(NWIN)) u_map (
      .cwp_i(cwp), .lreg_i(port_lreg[p]),
      .glob_o(port_glob[p]), .gidx_o(port_gidx[p]), .pidx_o(port_pidx[p])
    );
  end

  assign pend    = ovf | unf;
  assign sf_pidx = PW'(twin) * PW'(WIN_SPAN) + PW'(sf_idx_i);

  rwin_store #(.DW(DW), .NPHYS(NPHYS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_glob_i(port_glob[0]), .a_gidx_i(port_gidx[0]), .a_pidx_i(port_pidx[0]), .a_data_o(rd_a_o),
    .b_glob_i(port_glob[1]), .b_gidx_i(port_gidx[1]), .b_pidx_i(port_pidx[1]), .b_data_o(rd_b_o),
    .w_en_i(wr_en_i), .w_glob_i(port_glob[2]), .w_gidx_i(port_gidx[2]), .w_pidx_i(port_pidx[2]),
    .w_data_i(wr_data_i),
    .sf_we_i(sf_we_i && pend), .sf_pidx_i(sf_pidx), .sf_wdata_i(sf_wdata_i), .sf_rdata_o(sf_rdata_o)
  );

  assign cwp_o      = cwp;
  assign ovf_trap_o = ovf;
  assign unf_trap_o = unf;
  assign trap_win_o = twin;

  AST_BOTH_PULSES_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i && !pend) |=> ($stable(cwp_o) && !ovf_trap_o && !unf_trap_o)); // R11
endmodule

// File: tb/rwin_file_bench.sv
`timescale 1ns/1ps
module rwin_file_bench;
  localparam int NWIN = 4;
  localparam int NP   = NWIN * 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, wr_en_i, trap_ack_i, sf_we_i;
  logic [4:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
  logic [31:0] wr_data_i, sf_wdata_i;
  logic [3:0]  sf_idx_i;
  logic [31:0] rd_a_o, rd_b_o, sf_rdata_o;
  logic [1:0]  cwp_o, trap_win_o;
  logic        ovf_trap_o, unf_trap_o;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_cwp, m_occ, m_st;
  logic [31:0] m_mem [int];
  logic [31:0] m_glob [8];

  always #10 clk = ~clk;

  rwin_file #(.NWIN(NWIN), .DW(32)) u_rwin_file (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .rd_a_idx_i(rd_a_idx_i), .rd_a_o(rd_a_o), .rd_b_idx_i(rd_b_idx_i), .rd_b_o(rd_b_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .cwp_o(cwp_o), .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o), .trap_win_o(trap_win_o),
    .trap_ack_i(trap_ack_i), .sf_idx_i(sf_idx_i), .sf_we_i(sf_we_i), .sf_wdata_i(sf_wdata_i),
    .sf_rdata_o(sf_rdata_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_tw();
    return (m_st == 1) ? (m_cwp + 2) % NWIN : (m_cwp + NWIN - 1) % NWIN;
  endfunction

  function automatic int m_phys(int w, int r);
    return (w * 16 + r - 8) % NP;
  endfunction

  function automatic bit m_read(int r, output logic [31:0] v);
    v = '0;
    if (r < 8) begin
      v = (r == 0) ? 32'd0 : m_glob[r];
      return (r == 0) || (m_glob[r] !== 32'hx);
    end
    if (!m_mem.exists(m_phys(m_cwp, r))) return 0;
    v = m_mem[m_phys(m_cwp, r)];
    return 1;
  endfunction

  task automatic compare_all();
    logic [31:0] v;
    chk("R6", 32'(cwp_o), 32'(m_cwp));
    chk("R7", 32'(ovf_trap_o), 32'(m_st == 1));
    chk("R8", 32'(unf_trap_o), 32'(m_st == 2));
    if (m_st != 0) begin
      chk("R7", 32'(trap_win_o), 32'(m_tw()));
      if (m_mem.exists(m_tw() * 16 + int'(sf_idx_i)))
        chk("R9", sf_rdata_o, m_mem[m_tw() * 16 + int'(sf_idx_i)]);
    end
    if (m_read(int'(rd_a_idx_i), v)) chk("R2", rd_a_o, v);
    if (m_read(int'(rd_b_idx_i), v)) chk("R2", rd_b_o, v);
  endtask

  task automatic model_update();
    int w;
    if (wr_en_i) begin
      w = int'(wr_idx_i);
      if (w >= 8) m_mem[m_phys(m_cwp, w)] = wr_data_i;
      else if (w != 0) m_glob[w] = wr_data_i;
    end
    if (m_st != 0 && sf_we_i) m_mem[m_tw() * 16 + int'(sf_idx_i)] = sf_wdata_i;
    case (m_st)
      0: begin
        if (call_i && !ret_i) begin
          if (m_occ == NWIN - 1) m_st = 1;
          else begin m_cwp = (m_cwp + 1) % NWIN; m_occ++; end
        end else if (ret_i && !call_i) begin
          if (m_occ == 1) m_st = 2;
          else begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_occ--; end
        end
      end
      1: if (trap_ack_i) begin m_cwp = (m_cwp + 1) % NWIN; m_st = 0; end
      default: if (trap_ack_i) begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_st = 0; end
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    @(posedge clk);
    #1;
    model_update();
  endtask

  task automatic idle_in();
    call_i = 0; ret_i = 0; wr_en_i = 0; trap_ack_i = 0; sf_we_i = 0;
    wr_idx_i = 0; wr_data_i = 0; sf_wdata_i = 0; sf_idx_i = 0;
    rd_a_idx_i = 0; rd_b_idx_i = 0;
  endtask

  task automatic wr(int r, logic [31:0] v);
    wr_en_i = 1; wr_idx_i = 5'(r); wr_data_i = v;
    tick();
    wr_en_i = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_glob[i] = 32'hx;
    m_cwp = 0; m_occ = 1; m_st = 0;
    idle_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    chk("R1", 32'(cwp_o), 0);
    chk("R1", 32'(ovf_trap_o), 0);
    chk("R1", 32'(unf_trap_o), 0);

    // R5: register 0
    wr(0, 32'hDEAD);
    rd_a_idx_i = 0; #2;
    chk("R5", rd_a_o, 32'h0);
    for (int i = 1; i < 8; i++) wr(i, 32'h1000 + i);
    for (int i = 8; i < 32; i++) wr(i, 32'h100 + i);

    // R10: read in the cycle of a call uses the old window
    rd_a_idx_i = 16; call_i = 1; #2;
    chk("R10", rd_a_o, 32'h110);
    tick();
    call_i = 0; #2;
    chk("R6", 32'(cwp_o), 1);

    // R3: callee params are caller temps
    rd_a_idx_i = 8; #2;
    chk("R3", rd_a_o, 32'h118);
    rd_a_idx_i = 3; #2;
    chk("R4", rd_a_o, 32'h1003);
    wr(15, 32'hAB);
    ret_i = 1; tick(); ret_i = 0;
    rd_a_idx_i = 31; #2;
    chk("R3", rd_a_o, 32'hAB);
    chk("R6", 32'(cwp_o), 0);
    call_i = 1; tick(); call_i = 0;

    // R12: same-cycle read returns old value
    wr(17, 32'h44);
    wr_en_i = 1; wr_idx_i = 17; wr_data_i = 32'h55; rd_a_idx_i = 17; #2;
    chk("R12", rd_a_o, 32'h44);
    tick();
    wr_en_i = 0; #2;
    chk("R12", rd_a_o, 32'h55);

    // R7: overflow
    call_i = 1; tick(); tick(); #2;
    chk("R7", 32'(ovf_trap_o), 1);
    chk("R7", 32'(trap_win_o), 0);
    tick(); tick(); call_i = 0; #2;
    chk("R11", 32'(cwp_o), 2);
    sf_idx_i = 0; #2;
    chk("R9", sf_rdata_o, 32'h108);
    sf_idx_i = 8; #2;
    chk("R9", sf_rdata_o, 32'h110);
    trap_ack_i = 1; tick(); trap_ack_i = 0; #2;
    chk("R7", 32'(cwp_o), 3);
    chk("R7", 32'(ovf_trap_o), 0);

    // R8: underflow and fill
    ret_i = 1; tick(); tick(); tick(); ret_i = 0; #2;
    chk("R8", 32'(unf_trap_o), 1);
    chk("R8", 32'(trap_win_o), 0);
    chk("R8", 32'(cwp_o), 1);
    sf_idx_i = 0; sf_we_i = 1; sf_wdata_i = 32'h777; tick(); sf_we_i = 0;
    trap_ack_i = 1; tick(); trap_ack_i = 0;
    rd_a_idx_i = 8; #2;
    chk("R9", rd_a_o, 32'h777);
    chk("R8", 32'(cwp_o), 0);

    // R11: call and return together
    call_i = 1; ret_i = 1; tick(); call_i = 0; ret_i = 0; #2;
    chk("R11", 32'(cwp_o), 0);
    chk("R11", 32'(unf_trap_o), 0);

    // random mix, compared every clock
    for (int n = 0; n < 4000; n++) begin
      wr_en_i    = ($urandom_range(1, 0) == 1);
      wr_idx_i   = 5'($urandom_range(31, 0));
      wr_data_i  = $urandom;
      rd_a_idx_i = 5'($urandom_range(31, 0));
      rd_b_idx_i = 5'($urandom_range(31, 0));
      call_i     = ($urandom_range(7, 0) == 0);
      ret_i      = ($urandom_range(7, 0) == 0);
      trap_ack_i = (m_st != 0) && ($urandom_range(5, 0) == 0);
      sf_we_i    = ($urandom_range(2, 0) == 0);
      sf_idx_i   = 4'($urandom_range(15, 0));
      sf_wdata_i = $urandom;
      tick();
    end
    idle_in();
    tick();

    done = 1;
    summary();
    $finish;
  end
endmodule